// File: doc/BRIEF.md
# SPI Clock-Calendar Register Slave

This block is the device side of a small real-time-clock peripheral reached over SPI. It holds sixteen byte-wide registers: the time and date fields (seconds, minutes, hours, weekday, day, month, year), an adjust byte, the alarm bytes and two control bytes. Time counting, oscillator behaviour and alarm matching are outside this block. It only stores the bytes and moves them across the serial link.

Every transaction starts with one command byte. The upper nibble of that byte is the start register. The low nibble selects one of four operations: a single read, a single write, a burst read or a burst write. Burst transfers step through consecutive registers and wrap at the top of the map. A parallel preset port lets local logic load any register directly. Serial inputs are taken to be synchronous to `clk`, and `sclk` must run well below the `clk` rate.

Top module: `rtc_spi_regs`

## Requirements
- R1: After reset every register reads 0x00, except register 15 (control 2). Register 15 reads 0x10, which is its oscillator-stop flag in bit 4.
- R2: In the command byte, bits 7:4 give the start address. The low nibble selects the operation: 0x8 single write, 0xC single read, 0x0 burst write, 0x4 burst read. While the command byte is being shifted, `miso` is 0.
- R3: Chip select is active high. `mosi` is sampled on the falling edge of `sclk`, and `miso` changes after the rising edge. Bytes travel most significant bit first. `miso` is 0 whenever `cs` is low.
- R4: A written byte is stored unchanged and reads back unchanged. This includes bit 5 of the hours register (PM flag) and bit 7 of the month register (century flag).
- R5: In burst mode the address advances by one after each data byte and wraps from 15 to 0.
- R6: A single access moves exactly one data byte. Further write bytes are ignored, and further read bytes return 0x00.
- R7: Lowering `cs` at any point ends the transaction and throws away any partial byte. The next byte after `cs` rises again is taken as a command.
- R8: Register 13 is not implemented. It always reads 0x00, and writes to it from the serial port or the preset port have no effect.
- R9: When `preset_we` is high on a clock edge, `preset_data` is written to register `preset_addr`.
- R10: Writing 0x00 to control 2 clears its oscillator-stop flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| preset_we | input | 1 | Parallel preset write strobe |
| preset_addr | input | 4 | Parallel preset register address |
| preset_data | input | 8 | Parallel preset data byte |

## Verification
Each `sclk` edge is seen one `clk` later. A serial write therefore lands on the `clk` edge that sees the eighth falling `sclk` edge. A preset write lands on the edge where `preset_we` is sampled. Both kinds of write are checked later by a serial read, long after they have settled. A read bit is on `miso` one `clk` after the rising `sclk` edge that shifts it out. The bench holds each `sclk` phase for four `clk` cycles and compares `miso` at the falling `sclk` edge, three cycles after the bit became valid.

// File: rtl/rtc_spi_regs.sv
module rtc_spi_regs #(
  parameter logic [3:0] HOLE_ADDR = 4'd13,
  parameter logic [7:0] CTL2_RST  = 8'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       sclk,
  input  logic       mosi,
  output logic       miso,
  input  logic       preset_we,
  input  logic [3:0] preset_addr,
  input  logic [7:0] preset_data
);

  logic             sclk_q;
  logic [2:0]       bit_cnt;
  logic [6:0]       rx;
  logic [6:0]       tx;
  logic             miso_r;
  logic             have_cmd, rd_op, burst, done;
  logic [3:0]       addr;
  logic [15:0][7:0] regs;

  wire       rise      = cs & sclk & ~sclk_q;
  wire       fall      = cs & ~sclk & sclk_q;
  wire [7:0] byte_in   = {rx, mosi};
  wire       byte_done = fall & (bit_cnt == 3'd7);
  wire       spi_wr    = byte_done & have_cmd & ~rd_op & ~done & (addr != HOLE_ADDR);
  wire [7:0] rd_byte   = (have_cmd & rd_op & ~done & (addr != HOLE_ADDR)) ? regs[addr] : 8'h00;

  assign miso = cs & miso_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx       <= '0;
      tx       <= '0;
      miso_r   <= 1'b0;
      have_cmd <= 1'b0;
      rd_op    <= 1'b0;
      burst    <= 1'b0;
      done     <= 1'b0;
      addr     <= '0;
    end else if (!cs) begin
      bit_cnt  <= '0;
      miso_r   <= 1'b0;
      have_cmd <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (fall) begin
        rx      <= {rx[5:0], mosi};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (!have_cmd) begin
            have_cmd <= 1'b1;
            addr     <= byte_in[7:4];
            rd_op    <= byte_in[2];
            burst    <= ~byte_in[3];
          end else if (burst) begin
            addr <= addr + 4'd1;
          end else begin
            done <= 1'b1;
          end
        end
      end
      if (rise) begin
        if (bit_cnt == 3'd0) begin
          miso_r <= rd_byte[7];
          tx     <= rd_byte[6:0];
        end else begin
          miso_r <= tx[6];
          tx     <= {tx[5:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs     <= '0;
      regs[15] <= CTL2_RST;
    end else if (spi_wr) begin
      regs[addr] <= byte_in;
    end else if (preset_we && preset_addr != HOLE_ADDR) begin
      regs[preset_addr] <= preset_data;
    end
  end

endmodule

// File: rtl/rtc_spi_regs_chk.sv
module rtc_spi_regs_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             preset_we,
  input logic [15:0][7:0] regs,
  input logic [3:0]       addr,
  input logic [2:0]       bit_cnt,
  input logic             byte_done,
  input logic             have_cmd,
  input logic             burst,
  input logic             done
);

  assert_hole_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    regs[13] == 8'h00);

  assert_cs_low_rearms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (bit_cnt == 3'd0 && !have_cmd && !done));

  assert_burst_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && have_cmd && burst) |=> addr == $past(addr) + 4'd1);

  assert_single_one_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && have_cmd && !burst) |=> done);

  assert_idle_regs_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !preset_we) |=> $stable(regs));

endmodule

bind rtc_spi_regs rtc_spi_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs        (cs),
  .preset_we (preset_we),
  .regs      (regs),
  .addr      (addr),
  .bit_cnt   (bit_cnt),
  .byte_done (byte_done),
  .have_cmd  (have_cmd),
  .burst     (burst),
  .done      (done)
);

// File: tb/rtc_spi_regs_bench.sv
module rtc_spi_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0, cs = 0, sclk = 0, mosi = 0, miso;
  logic preset_we = 0;
  logic [3:0] preset_addr = 0;
  logic [7:0] preset_data = 0;

  int total = 0, fails = 0;
  logic [7:0] exp_q[$];
  bit         chk_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_spi_regs u_rtc_spi_regs (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .mosi(mosi), .miso(miso),
    .preset_we(preset_we), .preset_addr(preset_addr), .preset_data(preset_data));

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // monitor: assembles miso bytes at falling sclk and compares with the queue
  int mbit = 0;
  logic [7:0] mrx = 0;
  always @(negedge sclk or negedge cs) begin
    if (!cs) mbit = 0;
    else begin
      mrx = {mrx[6:0], miso};
      mbit++;
      if (mbit == 8) begin
        mbit = 0;
        if (exp_q.size() > 0) begin
          logic [7:0] e; bit c; string t;
          e = exp_q.pop_front(); c = chk_q.pop_front(); t = tag_q.pop_front();
          if (c) check(mrx, e, t);
        end
      end
    end
  end

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); sclk = 1; mosi = b[i];
      repeat (HALF) @(negedge clk);
      sclk = 0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit c, input logic [7:0] e, input string t);
    exp_q.push_back(e); chk_q.push_back(c); tag_q.push_back(t);
    send_bits(b, 8);
  endtask

  task automatic start(); @(negedge clk); cs = 1; repeat (2) @(negedge clk); endtask
  task automatic stop();  @(negedge clk); cs = 0; repeat (3) @(negedge clk); endtask

  task automatic wr1(input logic [3:0] a, input logic [7:0] v);
    start(); send({a, 4'h8}, 0, 0, ""); send(v, 0, 0, ""); stop();
  endtask

  task automatic rd1(input logic [3:0] a, input logic [7:0] e, input string t);
    start(); send({a, 4'hC}, 1, 8'h00, "R2"); send(8'h00, 1, e, t); stop();
  endtask

  task automatic preset(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); preset_we = 1; preset_addr = a; preset_data = v;
    @(negedge clk); preset_we = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check({7'd0, miso}, 8'h00, "R3");

    // R1 reset values
    rd1(4'd15, 8'h10, "R1");
    rd1(4'd0, 8'h00, "R1");
    check({7'd0, miso}, 8'h00, "R3");

    // R4 verbatim storage incl. PM and century flags
    wr1(4'd2, 8'h32); rd1(4'd2, 8'h32, "R4");
    wr1(4'd5, 8'h87); rd1(4'd5, 8'h87, "R4");

    // R10 oscillator-stop flag cleared by writing zero
    wr1(4'd15, 8'h00); rd1(4'd15, 8'h00, "R10");

    // R5 burst write and burst read
    start(); send(8'h00, 0, 0, "");
    send(8'h59, 0, 0, ""); send(8'h45, 0, 0, ""); send(8'h11, 0, 0, "");
    send(8'h06, 0, 0, ""); send(8'h28, 0, 0, ""); send(8'h12, 0, 0, "");
    send(8'h99, 0, 0, ""); stop();
    start(); send(8'h04, 1, 8'h00, "R2");
    send(0, 1, 8'h59, "R5"); send(0, 1, 8'h45, "R5"); send(0, 1, 8'h11, "R5");
    send(0, 1, 8'h06, "R5"); send(0, 1, 8'h28, "R5"); send(0, 1, 8'h12, "R5");
    send(0, 1, 8'h99, "R5"); stop();

    // R5 wrap from 15 to 0
    start(); send(8'hE0, 0, 0, "");
    send(8'hA5, 0, 0, ""); send(8'h00, 0, 0, ""); send(8'h3C, 0, 0, ""); stop();
    start(); send(8'hF4, 1, 8'h00, "R2");
    send(0, 1, 8'h00, "R5"); send(0, 1, 8'h3C, "R5"); send(0, 1, 8'h45, "R5"); stop();

    // R8 hole at address 13
    wr1(4'd13, 8'hFF); rd1(4'd13, 8'h00, "R8");
    preset(4'd13, 8'hFF); rd1(4'd13, 8'h00, "R8");
    start(); send(8'hC4, 1, 8'h00, "R2");
    send(0, 1, 8'h00, "R8"); send(0, 1, 8'h00, "R8"); send(0, 1, 8'hA5, "R8"); stop();

    // R6 single access moves one byte
    start(); send(8'h48, 0, 0, ""); send(8'h31, 0, 0, ""); send(8'h77, 0, 0, ""); stop();
    rd1(4'd4, 8'h31, "R6");
    rd1(4'd5, 8'h12, "R6");
    start(); send(8'h4C, 1, 8'h00, "R2");
    send(0, 1, 8'h31, "R6"); send(0, 1, 8'h00, "R6"); stop();

    // R7 abort discards partial byte and rearms command reception
    start(); send(8'h18, 0, 0, ""); send_bits(8'hFF, 5); stop();
    rd1(4'd1, 8'h45, "R7");
    start(); send_bits(8'h0C, 3); stop();
    rd1(4'd0, 8'h3C, "R7");

    // R9 preset port
    preset(4'd7, 8'h5A); rd1(4'd7, 8'h5A, "R9");
    preset(4'd3, 8'h04); rd1(4'd3, 8'h04, "R9");
    check({7'd0, miso}, 8'h00, "R3");

    wait (exp_q.size() == 0);
    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule